// File: doc/BRIEF.md
# Error-Bounded Predictive Sample Encoder

This block takes a stream of signed fixed-point samples and shrinks it. Each incoming sample is compared against three guesses built from the values a decoder would already hold. The first guess repeats the last value. The second continues a straight line through the last two values. The third continues a parabola through the last three values. If a guess lands within a programmable absolute error of the real sample, the sample leaves the block as a 2-bit selector naming that guess. Otherwise the block emits an escape selector, and the exact value goes out on a separate literal stream in the same beat.

The history the guesses are built from is not the raw input. It is the reconstruction: the chosen guess for a coded sample and the exact value for a literal. A decoder that replays the selectors and literals therefore tracks the encoder exactly, and the error bound holds per sample without drift. Guesses that need more history than has been seen since reset are switched off.

Top module: `pred_stream_enc`

## Requirements
- R1: After reset, `code_valid` and `lit_valid` are low and `in_ready` is high.
- R2: Selector encoding: 00 means repeat x1, 01 means 2·x1 − x2, and 10 means 3·x1 − 3·x2 + x3, where x1 is the newest reconstructed value. A guess p is accepted when |x − p| ≤ `err_bound`, with `err_bound` read as unsigned.
- R3: When more than one guess is accepted, the smallest selector value is emitted.
- R4: Selector 11 is emitted when no guess is accepted. `lit_valid` is high exactly when a valid selector is 11, and `lit_data` then equals the input sample exactly.
- R5: History holds reconstructed values: the accepted guess for coded samples and the input for literals.
- R6: After reset, the first sample is always 11, the second can only be 00 or 11, and the third can never be 10.
- R7: A pending output stays stable until it is drained. A coded beat drains on `code_ready`. A literal beat drains only when `code_ready` and `lit_ready` are both high, and both streams move together.
- R8: `in_ready` is high when the output slot is empty or draining in that cycle. With both readies high, one sample is taken every cycle.
- R9: With `err_bound` = 0, only exact guesses are accepted.
- R10: A guess outside the signed DW-bit range is never accepted, even when it lies within the bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| err_bound | input | DW | Unsigned absolute error bound |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Encoder can take a sample |
| in_data | input | DW | Signed input sample |
| code_valid | output | 1 | Selector beat valid |
| code_ready | input | 1 | Selector consumer ready |
| code_out | output | 2 | Predictor selector, 11 = literal follows |
| lit_valid | output | 1 | Literal beat valid |
| lit_ready | input | 1 | Literal consumer ready |
| lit_data | output | DW | Exact value of an unpredictable sample |

## Verification
A corrupted history register does not show up right away. It appears on a later sample as a selector that differs from the one an independent reference chooses, usually within one to three samples, depending on which of x1..x3 is wrong. A drift case with a small bound separates reconstructed history from raw history on the fourth sample. A broken warm-up count shows up on the second or third sample after reset. A handshake fault shows up as a lost or duplicated beat in the scoreboard order, or as a literal that moves without its selector.

// File: rtl/pred_enc_pkg.sv
package pred_enc_pkg;

    localparam int NUM_PRED = 3;

    typedef enum logic [1:0] {
        CODE_HOLD  = 2'b00,
        CODE_LINE  = 2'b01,
        CODE_CURVE = 2'b10,
        CODE_RAW   = 2'b11
    } pred_code_e;

endpackage

// File: rtl/pred_enc_history.sv
module pred_enc_history #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic signed [DW-1:0] push_val,
    output logic signed [DW-1:0] hist_x1,
    output logic signed [DW-1:0] hist_x2,
    output logic signed [DW-1:0] hist_x3,
    output logic [1:0]           depth
);

    typedef struct packed {
        logic signed [DW-1:0] x1;
        logic signed [DW-1:0] x2;
        logic signed [DW-1:0] x3;
        logic [1:0]           depth;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (push) begin
            hist_d.x3 = hist_q.x2;
            hist_d.x2 = hist_q.x1;
            hist_d.x1 = push_val;
            if (hist_q.depth != 2'd3) begin
                hist_d.depth = hist_q.depth + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_x1 = hist_q.x1;
    assign hist_x2 = hist_q.x2;
    assign hist_x3 = hist_q.x3;
    assign depth   = hist_q.depth;

endmodule

// File: rtl/pred_enc_predict.sv
module pred_enc_predict
    import pred_enc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 3
) (
    input  logic signed [DW-1:0]             hist_x1,
    input  logic signed [DW-1:0]             hist_x2,
    input  logic signed [DW-1:0]             hist_x3,
    input  logic [1:0]                       depth,
    input  logic signed [DW-1:0]             sample,
    input  logic [DW-1:0]                    err_bound,
    output logic [NUM_PRED-1:0]              fit,
    output logic [NUM_PRED-1:0][DW-1:0]      pred
);

    localparam int PW  = DW + GUARD;
    localparam int XW  = PW + 1;
    localparam int TOP = PW - DW + 1;

    logic signed [PW-1:0] e1, e2, e3, ex;

    always_comb begin
        e1 = PW'(hist_x1);
        e2 = PW'(hist_x2);
        e3 = PW'(hist_x3);
        ex = PW'(sample);
    end

    for (genvar k = 0; k < NUM_PRED; k++) begin : g_pred
        logic signed [PW-1:0] p_wide;
        logic signed [XW-1:0] diff;
        logic [XW-1:0]        mag;
        logic                 in_range;
        logic                 avail;

        if (k == 0) begin : g_hold
            assign p_wide = e1;
        end else if (k == 1) begin : g_line
            assign p_wide = (e1 <<< 1) - e2;
        end else begin : g_curve
            assign p_wide = (e1 <<< 1) + e1 - ((e2 <<< 1) + e2) + e3;
        end

        always_comb begin
            diff     = XW'(ex) - XW'(p_wide);
            mag      = diff[XW-1] ? XW'(-diff) : XW'(diff);
            in_range = (p_wide[PW-1 -: TOP] == {TOP{1'b0}}) ||
                       (p_wide[PW-1 -: TOP] == {TOP{1'b1}});
            avail    = (depth > 2'(k));
            fit[k]   = avail && in_range && (mag <= XW'(err_bound));
            pred[k]  = p_wide[DW-1:0];
        end
    end

endmodule

// File: rtl/pred_enc_select.sv
module pred_enc_select
    import pred_enc_pkg::*;
(
    input  logic [NUM_PRED-1:0] fit,
    output pred_code_e          code
);

    always_comb begin
        code = CODE_RAW;
        for (int k = NUM_PRED - 1; k >= 0; k--) begin
            if (fit[k]) begin
                code = pred_code_e'(2'(k));
            end
        end
    end

endmodule

// File: rtl/pred_stream_enc.sv
module pred_stream_enc
    import pred_enc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        err_bound,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_data,
    output logic                 code_valid,
    input  logic                 code_ready,
    output logic [1:0]           code_out,
    output logic                 lit_valid,
    input  logic                 lit_ready,
    output logic signed [DW-1:0] lit_data
);

    typedef struct packed {
        logic                 full;
        pred_code_e           code;
        logic signed [DW-1:0] lit;
    } slot_t;

    slot_t slot_d, slot_q;

    logic signed [DW-1:0]          x1, x2, x3;
    logic [1:0]                    depth;
    logic [NUM_PRED-1:0]           fit;
    logic [NUM_PRED-1:0][DW-1:0]   pred;
    pred_code_e                    sel_code;
    logic signed [DW-1:0]          recon;
    logic                          drain;
    logic                          accept;

    pred_enc_history #(.DW(DW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_val (recon),
        .hist_x1  (x1),
        .hist_x2  (x2),
        .hist_x3  (x3),
        .depth    (depth)
    );

    pred_enc_predict #(.DW(DW), .GUARD(GUARD)) u_pred (
        .hist_x1   (x1),
        .hist_x2   (x2),
        .hist_x3   (x3),
        .depth     (depth),
        .sample    (in_data),
        .err_bound (err_bound),
        .fit       (fit),
        .pred      (pred)
    );

    pred_enc_select u_sel (
        .fit  (fit),
        .code (sel_code)
    );

    always_comb begin
        drain    = slot_q.full && code_ready &&
                   ((slot_q.code != CODE_RAW) || lit_ready);
        in_ready = !slot_q.full || drain;
        accept   = in_valid && in_ready;
        recon    = (sel_code == CODE_RAW) ? in_data : $signed(pred[sel_code]);

        slot_d = slot_q;
        if (drain) begin
            slot_d.full = 1'b0;
        end
        if (accept) begin
            slot_d.full = 1'b1;
            slot_d.code = sel_code;
            slot_d.lit  = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign code_valid = slot_q.full;
    assign code_out   = slot_q.code;
    assign lit_valid  = slot_q.full && (slot_q.code == CODE_RAW);
    assign lit_data   = slot_q.lit;

endmodule

// File: rtl/pred_enc_checker.sv
module pred_enc_checker #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic signed [DW-1:0] in_data,
    input logic                 code_valid,
    input logic                 code_ready,
    input logic [1:0]           code_out,
    input logic                 lit_valid,
    input logic                 lit_ready,
    input logic signed [DW-1:0] lit_data
);

    logic       drain;
    logic       take;
    logic [1:0] seen_q;

    assign drain = code_valid && code_ready && ((code_out != 2'b11) || lit_ready);
    assign take  = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 2'd0;
        end else if (take && seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    assert_lit_matches_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (lit_valid == (code_out == 2'b11)));

    assert_lit_needs_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lit_valid |-> code_valid);

    assert_lit_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((code_out != 2'b11) || (lit_data == $past(in_data))));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !drain) |=> (code_valid && $stable(code_out) && $stable(lit_data)));

    assert_ready_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> in_ready);

    assert_first_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && seen_q == 2'd0) |=> (code_out == 2'b11));

    assert_second_limited_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && seen_q == 2'd1) |=> (code_out == 2'b00 || code_out == 2'b11));

    assert_third_no_curve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && seen_q == 2'd2) |=> (code_out != 2'b10));

endmodule

bind pred_stream_enc pred_enc_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code_out   (code_out),
    .lit_valid  (lit_valid),
    .lit_ready  (lit_ready),
    .lit_data   (lit_data)
);

// File: tb/tb_pred_stream_enc.sv
module tb_pred_stream_enc;

    localparam int DW      = 16;
    localparam int CLK_PER = 10;
    localparam int SMAX    = 32767;
    localparam int SMIN    = -32768;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [DW-1:0]        err_bound = '0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic signed [DW-1:0] in_data = '0;
    logic                 code_valid;
    logic                 code_ready = 1'b1;
    logic [1:0]           code_out;
    logic                 lit_valid;
    logic                 lit_ready = 1'b1;
    logic signed [DW-1:0] lit_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cycles   = 0;
    logic bp_en   = 1'b0;

    int exp_code[$];
    int exp_lit[$];
    int obs_code[$];

    int h1, h2, h3, hcnt;
    int bound_i;

    pred_stream_enc #(.DW(DW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_bound  (err_bound),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .code_valid (code_valid),
        .code_ready (code_ready),
        .code_out   (code_out),
        .lit_valid  (lit_valid),
        .lit_ready  (lit_ready),
        .lit_data   (lit_data)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cycles++;

    always @(posedge clk) begin
        #1;
        if (bp_en) begin
            code_ready = ($urandom % 4) != 0;
            lit_ready  = ($urandom % 3) != 0;
        end else begin
            code_ready = 1'b1;
            lit_ready  = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // reference encoder built from R2, R3, R5, R6, R9, R10
    task automatic model(input int x, output int code, output int recon);
        int p[3];
        code  = 3;
        recon = x;
        p[0] = h1;
        p[1] = 2 * h1 - h2;
        p[2] = 3 * h1 - 3 * h2 + h3;
        for (int k = 2; k >= 0; k--) begin
            int d;
            d = x - p[k];
            if (d < 0) d = -d;
            if (hcnt > k && p[k] >= SMIN && p[k] <= SMAX && d <= bound_i) begin
                code  = k;
                recon = p[k];
            end
        end
        h3 = h2;
        h2 = h1;
        h1 = recon;
        if (hcnt < 3) hcnt++;
    endtask

    // monitor: pops the scoreboard on each completed output beat
    always @(negedge clk) begin
        if (rst_n && code_valid) begin
            check(lit_valid == (code_out == 2'b11), "R4 lit_valid vs code", lit_valid, code_out == 2'b11);
            if (code_ready && (code_out != 2'b11 || lit_ready)) begin
                if (exp_code.size() == 0) begin
                    check(1'b0, "R7 unexpected beat", code_out, -1);
                end else begin
                    int ec, el;
                    ec = exp_code.pop_front();
                    el = exp_lit.pop_front();
                    obs_code.push_back(code_out);
                    check(code_out == ec, "R2 selector", code_out, ec);
                    if (ec == 3) check($signed(lit_data) == el, "R4 literal", $signed(lit_data), el);
                end
            end
        end
    end

    task automatic send(input int x);
        bit acc;
        int c, r;
        in_valid = 1'b1;
        in_data  = DW'(x);
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        model(x, c, r);
        exp_code.push_back(c);
        exp_lit.push_back(x);
        in_valid = 1'b0;
    endtask

    task automatic drain_out();
        int guard = 0;
        while (exp_code.size() != 0 && guard < 2000) begin
            @(posedge clk);
            guard++;
        end
        check(exp_code.size() == 0, "R7 drain", exp_code.size(), 0);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int bnd);
        rst_n     = 1'b0;
        bound_i   = bnd;
        err_bound = DW'(bnd);
        h1 = 0; h2 = 0; h3 = 0; hcnt = 0;
        obs_code.delete();
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic expect_codes(input string req, input int a, input int b, input int c, input int d);
        int e[4];
        e = '{a, b, c, d};
        for (int i = 0; i < 4; i++) begin
            int got;
            got = (obs_code.size() > i) ? obs_code[i] : -1;
            check(got == e[i], req, got, e[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset(0);
        @(negedge clk);
        check(code_valid == 1'b0, "R1 code_valid", code_valid, 0);
        check(lit_valid == 1'b0, "R1 lit_valid", lit_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        @(posedge clk); #1;

        // R9 R3 constant run, exact bound: literal then repeats
        send(5); send(5); send(5); send(5);
        drain_out();
        expect_codes("R9 constant", 3, 0, 0, 0);

        // R2 R3 ramp selects the line predictor ahead of the curve
        do_reset(0);
        send(10); send(20); send(30); send(40);
        drain_out();
        expect_codes("R3 ramp", 3, 3, 1, 1);

        // R2 R6 squares: curve only from the fourth sample
        do_reset(0);
        send(0); send(1); send(4); send(9);
        drain_out();
        expect_codes("R6 squares", 3, 3, 3, 2);

        // R5 reconstructed history under bound 2
        do_reset(2);
        send(100); send(101); send(102); send(103);
        drain_out();
        expect_codes("R5 drift", 3, 0, 0, 3);

        // R10 out-of-range line guess within bound is refused
        do_reset(60);
        send(32600); send(32700); send(32767);
        drain_out();
        begin
            int got;
            got = (obs_code.size() > 2) ? obs_code[2] : -1;
            check(got == 3, "R10 range", got, 3);
        end

        // R8 full throughput with readies high
        do_reset(4);
        begin
            int t0;
            t0 = cycles;
            for (int i = 0; i < 8; i++) send(i * 3);
            check(cycles - t0 == 8, "R8 throughput", cycles - t0, 8);
        end
        drain_out();

        // R7 R4 random walk under backpressure
        do_reset(3);
        bp_en = 1'b1;
        begin
            int x;
            x = 0;
            for (int i = 0; i < 400; i++) begin
                if ($urandom % 16 == 0) x = int'($urandom % 60000) - 30000;
                else x = x + int'($urandom % 9) - 4;
                if (x > SMAX) x = SMAX;
                if (x < SMIN) x = SMIN;
                send(x);
            end
        end
        drain_out();
        bp_en = 1'b0;

        // R4 extremes as literals with exact bound
        do_reset(0);
        send(SMAX); send(SMIN); send(SMAX); send(0);
        drain_out();

        finish_run();
    end

endmodule